// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of general-purpose I/O lines (32 by default) controlled through a small word-addressed register bus. Software sets each line's direction, output value, open-drain behaviour and input gating. It reads back a data view that mixes driven outputs with sampled inputs. The pads appear as three line-indexed vectors: the value to drive, the output enable, and the value seen on the pin.

Every pin goes through a two-stage synchroniser and is then checked for transitions. A per-line control bit chooses the edge type: falling edges only, or both edges. A detected edge sets a sticky pending bit. Software clears a pending bit by writing 1 to it. The block raises a single registered interrupt output when at least one pending bit is set and its mask bit is also set.

Register bits use reversed numbering. Line n sits at bit (NLINES-1-n), so line 0 is the most significant bit. This applies to every register.

Top module: `gpio_irq_bank`

## Requirements
- R1: A synchronous active-high reset clears every register. After the reset edge, bus_rdata, irq_o, pad_out and pad_oe are all 0.
- R2: The word addresses are: direction 0, open-drain 1, data 2, pending 3, mask 4, edge-select 5, input-enable 6. Direction, open-drain, mask, edge-select and input-enable read back the last value written to them. Address 7 reads 0.
- R3: Line n maps to bit (NLINES-1-n) in every register. Pad vectors are indexed by line number.
- R4: A direction bit of 1 makes the line an output and a 0 makes it an input. pad_oe is never asserted for an input line.
- R5: A read of the data register returns, for each bit, one of three values. For an output line it returns the written data bit. For an input line with its input-enable bit at 1 it returns the synchronised pin. For an input line with its input-enable bit at 0 it returns 0.
- R6: pad_out equals the data bit ANDed with NOT open-drain. When a line has its open-drain bit set, pad_oe is asserted only when the line is an output and its data bit is 0, so such a line is only ever driven low.
- R7: With its edge-select bit at 1, a line records only falling edges. With the bit at 0, it records both rising and falling edges.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: If an edge is detected in the same cycle as a clear write to the same bit, the bit stays set.
- R10: irq_o is registered. It is 1 in the cycle after any bit of (pending AND mask) is 1. Writing mask 0 and pending all ones leaves irq_o low.
- R11: A pin change driven before clock edge k sets its pending bit at edge k+2, and raises irq_o at edge k+3.
- R12: A read takes one cycle: bus_rdata updates on the edge that samples bus_rd_en and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Registered read data |
| pad_in | input | NLINES | Pin levels, indexed by line |
| pad_out | output | NLINES | Value to drive, indexed by line |
| pad_oe | output | NLINES | Output enable, indexed by line |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets five corner cases.

- Bit reversal: a design without it would drive line 31's pad when line 0 was written.
- Open-drain line holding a 1: a faulty design would drive that pad high instead of releasing it.
- Pending clear hitting in the same cycle as a new edge: a clear-priority design would silently lose the event.
- Falling-only edge selection: a wrong design would record the rising edge too.
- Input-enable gating: a wrong design would leak an ungated pin into the data view.

The bench also pins the exact synchroniser and interrupt latency. A design with one flop too many or too few would be off by a cycle in the every-clock comparison against the behavioural model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 3;

  // Word addresses of the register file.
  typedef enum logic [REG_AW-1:0] {
    RA_DIR       = 3'd0,
    RA_OPENDRAIN = 3'd1,
    RA_DATA      = 3'd2,
    RA_PENDING   = 3'd3,
    RA_MASK      = 3'd4,
    RA_EDGESEL   = 3'd5,
    RA_INBUF     = 3'd6,
    RA_SPARE     = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int unsigned NLINES = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pin_i,
  input  logic [NLINES-1:0] fall_only_i,
  output logic [NLINES-1:0] level_o,
  output logic [NLINES-1:0] edge_o
);
  localparam int unsigned HIST = STAGES + 1;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [HIST-1:0] shreg;
    logic            cur;
    logic            prev;

    always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[HIST-2:0], pin_i[g]};
    end

    assign cur  = shreg[STAGES-1];
    assign prev = shreg[STAGES];
    assign level_o[g] = cur;
    assign edge_o[g]  = fall_only_i[g] ? (prev & ~cur) : (prev ^ cur);

    // R7: a falling-only line reports an edge only after a high-to-low step
    a_r7_fall_only: assert property (@(posedge clk) disable iff (rst)
      (edge_o[g] && fall_only_i[g]) |-> (!level_o[g] && $past(level_o[g])));
  end
endmodule

// File: rtl/gpio_event_reg.sv
module gpio_event_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] evt_o
);
  always_ff @(posedge clk) begin
    if (rst) evt_o <= '0;
    else     evt_o <= (evt_o & ~clr_i) | set_i;
  end

  // R9: a new edge wins over a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((evt_o & $past(set_i)) == $past(set_i)));

  // R8: cleared bits without a new edge are gone next cycle
  a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((evt_o & $past(clr_i & ~set_i)) == '0));

  // R8: no clear and no edge keeps the pending state
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0 && set_i == '0) |=> $stable(evt_o));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] dir_i,
  input  logic [NLINES-1:0] odr_i,
  input  logic [NLINES-1:0] dat_i,
  output logic [NLINES-1:0] pad_out_o,
  output logic [NLINES-1:0] pad_oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_o <= '0;
      pad_oe_o  <= '0;
    end else begin
      pad_out_o <= dat_i & ~odr_i;
      pad_oe_o  <= dir_i & (~odr_i | ~dat_i);
    end
  end

  // R6: an open-drain line never drives a high level
  a_r6_od_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out_o & $past(odr_i)) == '0));

  // R4: an input line is never driven
  a_r4_input_released: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe_o & ~$past(dir_i)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr_en,
  input  logic                  bus_rd_en,
  input  logic [REG_AW-1:0]     bus_addr,
  input  logic [NLINES-1:0]     bus_wdata,
  output logic [NLINES-1:0]     bus_rdata,
  input  logic [NLINES-1:0]     pad_in,
  output logic [NLINES-1:0]     pad_out,
  output logic [NLINES-1:0]     pad_oe,
  output logic                  irq_o
);
  localparam int unsigned MSB = NLINES - 1;

  reg_addr_e            addr_e;
  logic [NLINES-1:0]    dir_q, odr_q, dat_q, msk_q, esel_q, ibe_q;
  logic [NLINES-1:0]    evt_q;
  logic [NLINES-1:0]    clr_bus;
  logic [NLINES-1:0]    data_view;

  // line-indexed views
  logic [NLINES-1:0]    dir_ln, odr_ln, dat_ln, esel_ln;
  logic [NLINES-1:0]    lvl_ln, edge_ln;
  // bus-bit views of line signals
  logic [NLINES-1:0]    lvl_bus, edge_bus;

  assign addr_e = reg_addr_e'(bus_addr);

  // R3: reversed numbering between register bits and line indices
  for (genvar g = 0; g < NLINES; g++) begin : g_rev
    assign dir_ln[g]      = dir_q[MSB-g];
    assign odr_ln[g]      = odr_q[MSB-g];
    assign dat_ln[g]      = dat_q[MSB-g];
    assign esel_ln[g]     = esel_q[MSB-g];
    assign lvl_bus[MSB-g] = lvl_ln[g];
    assign edge_bus[MSB-g] = edge_ln[g];
  end

  // Control register file
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      odr_q  <= '0;
      dat_q  <= '0;
      msk_q  <= '0;
      esel_q <= '0;
      ibe_q  <= '0;
    end else if (bus_wr_en) begin
      unique case (addr_e)
        RA_DIR:       dir_q  <= bus_wdata;
        RA_OPENDRAIN: odr_q  <= bus_wdata;
        RA_DATA:      dat_q  <= bus_wdata;
        RA_MASK:      msk_q  <= bus_wdata;
        RA_EDGESEL:   esel_q <= bus_wdata;
        RA_INBUF:     ibe_q  <= bus_wdata;
        default:      ;
      endcase
    end
  end

  assign clr_bus = (bus_wr_en && addr_e == RA_PENDING) ? bus_wdata : '0;

  // R5: outputs read their latch, inputs read the gated synchronised pin
  assign data_view = (dat_q & dir_q) | (lvl_bus & ~dir_q & ibe_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      unique case (addr_e)
        RA_DIR:       bus_rdata <= dir_q;
        RA_OPENDRAIN: bus_rdata <= odr_q;
        RA_DATA:      bus_rdata <= data_view;
        RA_PENDING:   bus_rdata <= evt_q;
        RA_MASK:      bus_rdata <= msk_q;
        RA_EDGESEL:   bus_rdata <= esel_q;
        RA_INBUF:     bus_rdata <= ibe_q;
        default:      bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(evt_q & msk_q);
  end

  gpio_sync_edge #(.NLINES(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .pin_i       (pad_in),
    .fall_only_i (esel_ln),
    .level_o     (lvl_ln),
    .edge_o      (edge_ln)
  );

  gpio_event_reg #(.WIDTH(NLINES)) u_evt (
    .clk   (clk),
    .rst   (rst),
    .set_i (edge_bus),
    .clr_i (clr_bus),
    .evt_o (evt_q)
  );

  gpio_pad_drive #(.NLINES(NLINES)) u_pads (
    .clk       (clk),
    .rst       (rst),
    .dir_i     (dir_ln),
    .odr_i     (odr_ln),
    .dat_i     (dat_ln),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe)
  );

  // R1: reset leaves every output quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && irq_o == 1'b0 && pad_oe == '0 && pad_out == '0));

  // R10: interrupt follows masked pending one cycle later
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(evt_q & msk_q))));

  // R12: read data holds while no read is issued
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] rdata, pad_out, pad_oe;
  logic         irq;

  int nchk = 0;
  int nbad = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [N-1:0] m_reg [0:7];      // indexed by word address; [2] is data latch
  bit [N-1:0] m_evt, m_rdata, m_pout, m_poe;
  bit         m_irq;
  bit [N-1:0] h1, h2, h3;       // pin history, indexed by line

  always @(posedge clk) begin
    bit [N-1:0] edges, view, npo, npoe;
    bit cur, prv;
    started = 1;
    if (rst) begin
      for (int a = 0; a < 8; a++) m_reg[a] = '0;
      m_evt = '0; m_rdata = '0; m_pout = '0; m_poe = '0; m_irq = 0;
      h1 = '0; h2 = '0; h3 = '0;
    end else begin
      edges = '0; view = '0; npo = '0; npoe = '0;
      for (int n = 0; n < N; n++) begin
        int b;
        b = N - 1 - n;
        cur = h2[n]; prv = h3[n];
        if (m_reg[5][b]) edges[b] = prv && !cur;
        else             edges[b] = prv != cur;
        if (m_reg[0][b]) view[b] = m_reg[2][b];
        else             view[b] = m_reg[6][b] && cur;
        npo[n]  = m_reg[2][b] && !m_reg[1][b];
        npoe[n] = m_reg[0][b] && !(m_reg[1][b] && m_reg[2][b]);
      end
      if (rd_en) begin
        if (addr == 3'd2)      m_rdata = view;
        else if (addr == 3'd3) m_rdata = m_evt;
        else if (addr == 3'd7) m_rdata = '0;
        else                   m_rdata = m_reg[addr];
      end
      m_irq = |(m_evt & m_reg[4]);
      m_pout = npo; m_poe = npoe;
      if (wr_en && addr == 3'd3) m_evt = m_evt & ~wdata;
      m_evt = m_evt | edges;
      if (wr_en && addr != 3'd3 && addr != 3'd7) m_reg[addr] = wdata;
      h3 = h2; h2 = h1; h1 = pad_in;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5 rdata vs model", rdata, m_rdata);
      chk("R10 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      chk("R6 pad_out vs model", pad_out, m_pout);
      chk("R4 pad_oe vs model", pad_oe, m_poe);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 and R2: everything reads zero, spare address too
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk((a == 7) ? "R2 spare address" : "R1 reset value", v, '0);
    end
    chk("R1 pads after reset", pad_oe | pad_out, '0);

    // R3/R4: lines 0..3 outputs, data on lines 0 and 2
    wr(3'd0, 32'hF000_0000);
    wr(3'd2, 32'hA000_0000);
    idle(2);
    chk("R4 output enables", pad_oe, 32'h0000_000F);
    chk("R3 reversed line order", pad_out, 32'h0000_0005);
    rd(3'd0, v);
    chk("R2 direction readback", v, 32'hF000_0000);

    // R6: open-drain on line 0
    wr(3'd1, 32'h8000_0000);
    idle(2);
    chk("R6 od high releases", pad_oe, 32'h0000_000E);
    chk("R6 od pad_out", pad_out, 32'h0000_0004);
    wr(3'd2, 32'h2000_0000);
    idle(2);
    chk("R6 od low drives", pad_oe, 32'h0000_000F);
    chk("R6 od low value", pad_out, 32'h0000_0004);

    // R5: input gating on lines 4..7; lines 4 and 8 go high
    wr(3'd6, 32'h0F00_0000);
    @(negedge clk); pad_in[4] = 1; pad_in[8] = 1;
    idle(4);
    rd(3'd2, v);
    chk("R5 data view", v, 32'h2800_0000);

    // R7 both edges; R8 clear behaviour
    rd(3'd3, v);
    chk("R7 rising edges recorded", v, 32'h0880_0000);
    wr(3'd3, 32'h0);
    rd(3'd3, v);
    chk("R8 write zero keeps", v, 32'h0880_0000);
    wr(3'd3, 32'h0800_0000);
    rd(3'd3, v);
    chk("R8 write one clears", v, 32'h0080_0000);

    // R10 masking and software init
    chk("R10 masked off", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'h0080_0000);
    idle(2);
    chk("R10 unmasked raises", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'hFFFF_FFFF);
    idle(2);
    chk("R10 init quiet", {31'd0, irq}, 32'd0);

    // R7 falling-only on line 9
    wr(3'd5, 32'h0040_0000);
    @(negedge clk); pad_in[9] = 1;
    idle(4);
    rd(3'd3, v);
    chk("R7 fall-only ignores rise", v, 32'h0);
    @(negedge clk); pad_in[9] = 0;
    idle(4);
    rd(3'd3, v);
    chk("R7 fall-only records fall", v, 32'h0040_0000);
    wr(3'd3, 32'hFFFF_FFFF);

    // R11 latency on line 10
    wr(3'd4, 32'h0020_0000);
    @(negedge clk); pad_in[10] = 1;   // before edge k
    @(negedge clk);                    // after k
    @(negedge clk);                    // after k+1
    chk("R11 irq low at k+1", {31'd0, irq}, 32'd0);
    @(negedge clk);                    // after k+2
    chk("R11 irq low at k+2", {31'd0, irq}, 32'd0);
    @(negedge clk);                    // after k+3
    chk("R11 irq high at k+3", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'hFFFF_FFFF);

    // R9 set beats clear on line 11
    @(negedge clk); pad_in[11] = 1;   // before edge k
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 3'd3; wdata = 32'hFFFF_FFFF; // at k+2
    @(negedge clk); wr_en = 0;
    rd(3'd3, v);
    chk("R9 edge survives clear", v, 32'h0010_0000);

    // R12 read hold
    rd(3'd0, v);
    idle(3);
    chk("R12 rdata holds", rdata, 32'hF000_0000);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 3) == 0);
      rd_en = ($urandom_range(0, 1) == 0);
      addr  = 3'($urandom_range(0, 7));
      wdata = $urandom;
      if ($urandom_range(0, 2) == 0) pad_in = pad_in ^ (32'd1 << $urandom_range(0, 31));
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule